// File: doc/BRIEF.md
# Isochronous Frame Completion Monitor

This block follows the isochronous endpoints of a full-speed USB device controller from one periodic frame to the next. It handles four isochronous IN endpoints and four isochronous OUT endpoints. Each IN endpoint holds three pieces of state: an armed bit, an even/odd frame selector and a per-frame done flag. Each OUT endpoint holds an armed bit and a done flag. Software arms an endpoint. A successful transfer completes it and disarms it in the same step. When the one-cycle end-of-frame pulse arrives, any endpoint that is still armed and due raises one of two global sticky interrupts, one for IN and one for OUT.

The block also judges every received isochronous OUT packet. A packet is thrown away when the receive FIFO has too little room for it, when its CRC is bad, or when the OUT token that came before it was corrupted. A thrown-away packet never completes its endpoint, and the endpoint stays armed. The cause of the drop is reported for one cycle.

The interrupts are single global flags and do not say which endpoint failed. Software finds the failing endpoint from the per-endpoint armed, parity and done outputs.

Top module: `iso_frame_monitor`

## Requirements
- R1: While `rst` is high at a clock edge, every output is 0 after that edge: all armed, parity and done vectors, `out_drop`, `out_drop_cause` and both interrupts.
- R2: An IN endpoint completes when all of the following hold: an error-free IN token addresses it, it is armed, its transmit data has been fully loaded this frame (an `in_data_loaded` pulse since the last frame end), and its selector equals `frame_num[0]` (selector 0 = even, 1 = odd). One cycle later its done bit is 1 and its armed bit is 0.
- R3: An IN token that is flagged in error, or that arrives before the endpoint's data has been loaded, leaves that endpoint's armed and done bits unchanged.
- R4: An `in_set_odd` pulse makes the selector 1. An `in_set_even` pulse makes it 0. If both arrive in the same cycle, odd wins. Otherwise the selector holds its value.
- R5: At an end-of-frame pulse, `in_incomplete_irq` becomes 1 on the next cycle if any IN endpoint is armed and its selector equals `frame_num[0]`. An armed endpoint whose selector does not match does not raise it.
- R6: An OUT packet is dropped if its length exceeds `rx_fifo_free`, if `out_crc_ok` is 0, or if `out_tok_ok` is 0. On the next cycle `out_drop` is 1 and `out_drop_cause` has bit 0 = FIFO too small, bit 1 = bad CRC, bit 2 = bad token. The endpoint's done bit does not change and its armed bit stays set.
- R7: A packet that is not dropped and addresses an armed OUT endpoint sets that endpoint's done bit and clears its armed bit. A length equal to the free space is accepted. The same packet sent to an unarmed endpoint changes nothing and is not reported as dropped.
- R8: At an end-of-frame pulse, `out_incomplete_irq` becomes 1 on the next cycle if any OUT endpoint is still armed.
- R9: Each interrupt is sticky until its clear pulse. A raise in the same cycle as the clear keeps the interrupt at 1.
- R10: An end-of-frame pulse clears every done bit and every loaded-data mark, and keeps the armed bits. A transfer presented in the end-of-frame cycle is not credited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_num | input | FRAME_W | Current frame number; bit 0 gives the frame parity |
| frame_end | input | 1 | One-cycle end-of-periodic-frame pulse |
| in_arm | input | NUM_IN | Arm pulse for each IN endpoint |
| in_set_even | input | NUM_IN | Force the IN selector to even |
| in_set_odd | input | NUM_IN | Force the IN selector to odd |
| in_data_loaded | input | NUM_IN | Pulse: transmit data fully written |
| in_tok_valid | input | 1 | IN token received |
| in_tok_ep | input | IN_EP_W | Endpoint addressed by the IN token |
| in_tok_err | input | 1 | IN token was in error |
| out_arm | input | NUM_OUT | Arm pulse for each OUT endpoint |
| out_pkt_valid | input | 1 | OUT packet received |
| out_pkt_ep | input | OUT_EP_W | Endpoint addressed by the OUT packet |
| out_pkt_len | input | LEN_W | Packet length in bytes |
| out_crc_ok | input | 1 | Packet CRC was good |
| out_tok_ok | input | 1 | OUT token was intact |
| rx_fifo_free | input | LEN_W | Free receive FIFO space in bytes |
| in_irq_clr | input | 1 | Write-one-to-clear pulse for the IN interrupt |
| out_irq_clr | input | 1 | Write-one-to-clear pulse for the OUT interrupt |
| in_enabled | output | NUM_IN | IN armed bits |
| in_odd | output | NUM_IN | IN frame selectors |
| in_done | output | NUM_IN | IN done bits for this frame |
| out_enabled | output | NUM_OUT | OUT armed bits |
| out_done | output | NUM_OUT | OUT done bits for this frame |
| out_drop | output | 1 | One-cycle drop report |
| out_drop_cause | output | 3 | Drop cause bits |
| in_incomplete_irq | output | 1 | Sticky incomplete-IN interrupt |
| out_incomplete_irq | output | 1 | Sticky incomplete-OUT interrupt |

## Verification
The assertions check on every cycle that the interrupts are sticky with raise-over-clear priority, that selector writes take effect, that an end-of-frame pulse wipes the done bits, and that a dropped or erroneous event never completes or disarms an endpoint. They also check that a fully qualified transfer completes and disarms its endpoint, and that a due endpoint at frame end raises its interrupt. Only the bench scenarios can show the system-level results: whether a parity mismatch suppresses the IN interrupt across successive frames, the exact drop-cause code for each failure, the equal-length boundary, and that a packet to an unarmed endpoint or in the end-of-frame cycle goes uncredited. The bench shows these through directed cases and a long random run against its model.

// File: rtl/iso_mon_pkg.sv
package iso_mon_pkg;

    localparam int unsigned CMP_W = 16;

    typedef enum logic [1:0] {
        SEL_HOLD = 2'd0,
        SEL_EVEN = 2'd1,
        SEL_ODD  = 2'd2
    } par_cmd_t;

    // bit 0 fifo, bit 1 crc, bit 2 token
    typedef struct packed {
        logic tok_bad;
        logic crc_bad;
        logic fifo_short;
    } drop_cause_t;

    function automatic par_cmd_t decode_par_cmd(input logic want_even, input logic want_odd);
        if (want_odd)
            return SEL_ODD;
        else if (want_even)
            return SEL_EVEN;
        return SEL_HOLD;
    endfunction

    function automatic logic parity_match(input logic sel_odd, input logic frame_lsb);
        return sel_odd == frame_lsb;
    endfunction

    function automatic drop_cause_t classify(input logic [CMP_W-1:0] len,
                                             input logic [CMP_W-1:0] room,
                                             input logic crc_ok,
                                             input logic tok_ok);
        drop_cause_t c;
        c.fifo_short = len > room;
        c.crc_bad    = !crc_ok;
        c.tok_bad    = !tok_ok;
        return c;
    endfunction

endpackage

// File: rtl/iso_sticky_irq.sv
module iso_sticky_irq (
    input  logic clk,
    input  logic rst,
    input  logic raise,
    input  logic clr,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (raise)
            q <= 1'b1;
        else if (clr)
            q <= 1'b0;
    end

    AST_IRQ_RAISE_WINS: assert property (@(posedge clk) disable iff (rst)
        raise |=> q);  // R9
    AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (clr && !raise) |=> !q);  // R9
    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!clr && !raise) |=> (q == $past(q)));  // R9

endmodule

// File: rtl/iso_in_bank.sv
module iso_in_bank
    import iso_mon_pkg::*;
#(
    parameter int unsigned NUM_EP = 4,
    parameter int unsigned EP_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_lsb,
    input  logic              frame_end,
    input  logic [NUM_EP-1:0] arm,
    input  logic [NUM_EP-1:0] set_even,
    input  logic [NUM_EP-1:0] set_odd,
    input  logic [NUM_EP-1:0] data_loaded,
    input  logic              tok_valid,
    input  logic [EP_W-1:0]   tok_ep,
    input  logic              tok_err,
    output logic [NUM_EP-1:0] en_q,
    output logic [NUM_EP-1:0] odd_q,
    output logic [NUM_EP-1:0] done_q,
    output logic              incomp_raise
);

    logic [NUM_EP-1:0] loaded_q;
    logic [NUM_EP-1:0] due;
    logic [NUM_EP-1:0] hit;

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        logic addressed;
        assign addressed = tok_valid && (tok_ep == EP_W'(i));
        assign due[i]    = en_q[i] && parity_match(odd_q[i], frame_lsb);
        assign hit[i]    = addressed && !tok_err && due[i] && loaded_q[i] && !frame_end;

        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[i]     <= 1'b0;
                odd_q[i]    <= 1'b0;
                done_q[i]   <= 1'b0;
                loaded_q[i] <= 1'b0;
            end else begin
                en_q[i] <= arm[i] | (en_q[i] & ~hit[i]);
                case (decode_par_cmd(set_even[i], set_odd[i]))
                    SEL_ODD:  odd_q[i] <= 1'b1;
                    SEL_EVEN: odd_q[i] <= 1'b0;
                    default:  odd_q[i] <= odd_q[i];
                endcase
                if (frame_end) begin
                    done_q[i]   <= 1'b0;
                    loaded_q[i] <= 1'b0;
                end else begin
                    done_q[i]   <= done_q[i] | hit[i];
                    loaded_q[i] <= (loaded_q[i] & ~hit[i]) | data_loaded[i];
                end
            end
        end

        AST_IN_HIT_DISARMS: assert property (@(posedge clk) disable iff (rst)
            (addressed && !tok_err && en_q[i] && loaded_q[i] && (odd_q[i] == frame_lsb)
             && !frame_end && !arm[i]) |=> (done_q[i] && !en_q[i]));  // R2
        AST_IN_ERR_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (addressed && tok_err && !arm[i]) |=> (en_q[i] == $past(en_q[i])));  // R3
        AST_IN_SEL_ODD: assert property (@(posedge clk) disable iff (rst)
            set_odd[i] |=> odd_q[i]);  // R4
        AST_IN_SEL_EVEN: assert property (@(posedge clk) disable iff (rst)
            (set_even[i] && !set_odd[i]) |=> !odd_q[i]);  // R4
        AST_IN_FRAME_WIPE: assert property (@(posedge clk) disable iff (rst)
            frame_end |=> !done_q[i]);  // R10
    end

    assign incomp_raise = frame_end && (|due);

endmodule

// File: rtl/iso_out_bank.sv
module iso_out_bank
    import iso_mon_pkg::*;
#(
    parameter int unsigned NUM_EP = 4,
    parameter int unsigned EP_W   = 2,
    parameter int unsigned LEN_W  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_end,
    input  logic [NUM_EP-1:0] arm,
    input  logic              pkt_valid,
    input  logic [EP_W-1:0]   pkt_ep,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic              crc_ok,
    input  logic              tok_ok,
    input  logic [LEN_W-1:0]  fifo_free,
    output logic [NUM_EP-1:0] en_q,
    output logic [NUM_EP-1:0] done_q,
    output logic              drop_q,
    output drop_cause_t       cause_q,
    output logic              incomp_raise
);

    drop_cause_t       cause;
    logic              bad;
    logic [NUM_EP-1:0] hit;

    assign cause = classify(CMP_W'(pkt_len), CMP_W'(fifo_free), crc_ok, tok_ok);
    assign bad   = pkt_valid && (cause != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            drop_q  <= 1'b0;
            cause_q <= '0;
        end else begin
            drop_q  <= bad;
            cause_q <= bad ? cause : '0;
        end
    end

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        logic addressed;
        assign addressed = pkt_valid && (pkt_ep == EP_W'(i));
        assign hit[i]    = addressed && !bad && en_q[i] && !frame_end;

        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[i]   <= 1'b0;
                done_q[i] <= 1'b0;
            end else begin
                en_q[i]   <= arm[i] | (en_q[i] & ~hit[i]);
                done_q[i] <= frame_end ? 1'b0 : (done_q[i] | hit[i]);
            end
        end

        AST_OUT_DROP_NO_DONE: assert property (@(posedge clk) disable iff (rst)
            (addressed && !crc_ok && !frame_end) |=> (done_q[i] == $past(done_q[i])));  // R6
        AST_OUT_DROP_KEEPS_ARM: assert property (@(posedge clk) disable iff (rst)
            (addressed && (pkt_len > fifo_free) && en_q[i]) |=> en_q[i]);  // R6
        AST_OUT_GOOD_COMPLETES: assert property (@(posedge clk) disable iff (rst)
            (addressed && en_q[i] && crc_ok && tok_ok && (pkt_len <= fifo_free)
             && !frame_end && !arm[i]) |=> (done_q[i] && !en_q[i]));  // R7
        AST_OUT_FRAME_WIPE: assert property (@(posedge clk) disable iff (rst)
            frame_end |=> !done_q[i]);  // R10
    end

    AST_OUT_CRC_REPORT: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !crc_ok) |=> (drop_q && cause_q.crc_bad));  // R6
    AST_OUT_QUIET_NO_DROP: assert property (@(posedge clk) disable iff (rst)
        !pkt_valid |=> (!drop_q && (cause_q == '0)));  // R6

    assign incomp_raise = frame_end && (|en_q);

endmodule

// File: rtl/iso_frame_monitor.sv
module iso_frame_monitor
    import iso_mon_pkg::*;
#(
    parameter int unsigned NUM_IN   = 4,
    parameter int unsigned NUM_OUT  = 4,
    parameter int unsigned FRAME_W  = 11,
    parameter int unsigned LEN_W    = 11,
    parameter int unsigned IN_EP_W  = $clog2(NUM_IN),
    parameter int unsigned OUT_EP_W = $clog2(NUM_OUT)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [FRAME_W-1:0]  frame_num,
    input  logic                frame_end,
    input  logic [NUM_IN-1:0]   in_arm,
    input  logic [NUM_IN-1:0]   in_set_even,
    input  logic [NUM_IN-1:0]   in_set_odd,
    input  logic [NUM_IN-1:0]   in_data_loaded,
    input  logic                in_tok_valid,
    input  logic [IN_EP_W-1:0]  in_tok_ep,
    input  logic                in_tok_err,
    input  logic [NUM_OUT-1:0]  out_arm,
    input  logic                out_pkt_valid,
    input  logic [OUT_EP_W-1:0] out_pkt_ep,
    input  logic [LEN_W-1:0]    out_pkt_len,
    input  logic                out_crc_ok,
    input  logic                out_tok_ok,
    input  logic [LEN_W-1:0]    rx_fifo_free,
    input  logic                in_irq_clr,
    input  logic                out_irq_clr,
    output logic [NUM_IN-1:0]   in_enabled,
    output logic [NUM_IN-1:0]   in_odd,
    output logic [NUM_IN-1:0]   in_done,
    output logic [NUM_OUT-1:0]  out_enabled,
    output logic [NUM_OUT-1:0]  out_done,
    output logic                out_drop,
    output logic [2:0]          out_drop_cause,
    output logic                in_incomplete_irq,
    output logic                out_incomplete_irq
);

    logic        in_raise;
    logic        out_raise;
    logic        unused_frame_hi;
    drop_cause_t cause_q;

    assign unused_frame_hi = ^frame_num[FRAME_W-1:1];

    iso_in_bank #(
        .NUM_EP (NUM_IN),
        .EP_W   (IN_EP_W)
    ) u_in_bank (
        .clk          (clk),
        .rst          (rst),
        .frame_lsb    (frame_num[0]),
        .frame_end    (frame_end),
        .arm          (in_arm),
        .set_even     (in_set_even),
        .set_odd      (in_set_odd),
        .data_loaded  (in_data_loaded),
        .tok_valid    (in_tok_valid),
        .tok_ep       (in_tok_ep),
        .tok_err      (in_tok_err),
        .en_q         (in_enabled),
        .odd_q        (in_odd),
        .done_q       (in_done),
        .incomp_raise (in_raise)
    );

    iso_out_bank #(
        .NUM_EP (NUM_OUT),
        .EP_W   (OUT_EP_W),
        .LEN_W  (LEN_W)
    ) u_out_bank (
        .clk          (clk),
        .rst          (rst),
        .frame_end    (frame_end),
        .arm          (out_arm),
        .pkt_valid    (out_pkt_valid),
        .pkt_ep       (out_pkt_ep),
        .pkt_len      (out_pkt_len),
        .crc_ok       (out_crc_ok),
        .tok_ok       (out_tok_ok),
        .fifo_free    (rx_fifo_free),
        .en_q         (out_enabled),
        .done_q       (out_done),
        .drop_q       (out_drop),
        .cause_q      (cause_q),
        .incomp_raise (out_raise)
    );

    assign out_drop_cause = cause_q;

    iso_sticky_irq u_in_irq (
        .clk   (clk),
        .rst   (rst),
        .raise (in_raise),
        .clr   (in_irq_clr),
        .q     (in_incomplete_irq)
    );

    iso_sticky_irq u_out_irq (
        .clk   (clk),
        .rst   (rst),
        .raise (out_raise),
        .clr   (out_irq_clr),
        .q     (out_incomplete_irq)
    );

    AST_IN_INCOMP_RAISE: assert property (@(posedge clk) disable iff (rst)
        (frame_end && |(in_enabled & ~(in_odd ^ {NUM_IN{frame_num[0]}}))) |=> in_incomplete_irq);  // R5
    AST_OUT_INCOMP_RAISE: assert property (@(posedge clk) disable iff (rst)
        (frame_end && |out_enabled) |=> out_incomplete_irq);  // R8
    AST_DROP_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        out_drop |-> (out_drop_cause != 3'b000));  // R6

endmodule

// File: tb/iso_frame_monitor_tb.sv
module iso_frame_monitor_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NI = 4;
    localparam int NO = 4;
    localparam int FW = 11;
    localparam int LW = 11;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          rst;
    logic [FW-1:0] frame_num;
    logic          frame_end;
    logic [NI-1:0] in_arm, in_set_even, in_set_odd, in_data_loaded;
    logic          in_tok_valid;
    logic [1:0]    in_tok_ep;
    logic          in_tok_err;
    logic [NO-1:0] out_arm;
    logic          out_pkt_valid;
    logic [1:0]    out_pkt_ep;
    logic [LW-1:0] out_pkt_len;
    logic          out_crc_ok, out_tok_ok;
    logic [LW-1:0] rx_fifo_free;
    logic          in_irq_clr, out_irq_clr;
    logic [NI-1:0] in_enabled, in_odd, in_done;
    logic [NO-1:0] out_enabled, out_done;
    logic          out_drop;
    logic [2:0]    out_drop_cause;
    logic          in_incomplete_irq, out_incomplete_irq;

    iso_frame_monitor u_dut (
        .clk(clk), .rst(rst), .frame_num(frame_num), .frame_end(frame_end),
        .in_arm(in_arm), .in_set_even(in_set_even), .in_set_odd(in_set_odd),
        .in_data_loaded(in_data_loaded), .in_tok_valid(in_tok_valid),
        .in_tok_ep(in_tok_ep), .in_tok_err(in_tok_err),
        .out_arm(out_arm), .out_pkt_valid(out_pkt_valid), .out_pkt_ep(out_pkt_ep),
        .out_pkt_len(out_pkt_len), .out_crc_ok(out_crc_ok), .out_tok_ok(out_tok_ok),
        .rx_fifo_free(rx_fifo_free), .in_irq_clr(in_irq_clr), .out_irq_clr(out_irq_clr),
        .in_enabled(in_enabled), .in_odd(in_odd), .in_done(in_done),
        .out_enabled(out_enabled), .out_done(out_done), .out_drop(out_drop),
        .out_drop_cause(out_drop_cause), .in_incomplete_irq(in_incomplete_irq),
        .out_incomplete_irq(out_incomplete_irq)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    // reference state
    logic [NI-1:0] m_in_en, m_in_odd, m_in_done, m_in_ld;
    logic [NO-1:0] m_out_en, m_out_done;
    logic          m_drop;
    logic [2:0]    m_cause;
    logic          m_irq_in, m_irq_out;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_cause(input logic [LW-1:0] len, input logic [LW-1:0] room,
                                             input logic crc, input logic tok);
        return {!tok, !crc, len > room};
    endfunction

    task automatic model_reset();
        m_in_en = '0; m_in_odd = '0; m_in_done = '0; m_in_ld = '0;
        m_out_en = '0; m_out_done = '0; m_drop = 0; m_cause = '0;
        m_irq_in = 0; m_irq_out = 0;
    endtask

    task automatic model_next();
        logic [NI-1:0] hi;
        logic [NO-1:0] ho;
        logic due_in, raise_out, bad;
        logic [2:0] c;
        due_in = 0;
        for (int i = 0; i < NI; i++) begin
            hi[i] = in_tok_valid && !in_tok_err && (in_tok_ep == i) && m_in_en[i] && m_in_ld[i]
                    && (m_in_odd[i] == frame_num[0]) && !frame_end;
            if (m_in_en[i] && (m_in_odd[i] == frame_num[0])) due_in = 1;
        end
        c   = exp_cause(out_pkt_len, rx_fifo_free, out_crc_ok, out_tok_ok);
        bad = out_pkt_valid && (c != 0);
        for (int i = 0; i < NO; i++)
            ho[i] = out_pkt_valid && !bad && (out_pkt_ep == i) && m_out_en[i] && !frame_end;
        raise_out = frame_end && (|m_out_en);
        // interrupts (R5, R8, R9)
        m_irq_in  = (frame_end && due_in) ? 1'b1 : (in_irq_clr ? 1'b0 : m_irq_in);
        m_irq_out = raise_out ? 1'b1 : (out_irq_clr ? 1'b0 : m_irq_out);
        for (int i = 0; i < NI; i++) begin
            m_in_en[i] = in_arm[i] | (m_in_en[i] & ~hi[i]);
            if (in_set_odd[i]) m_in_odd[i] = 1;
            else if (in_set_even[i]) m_in_odd[i] = 0;
            m_in_done[i] = frame_end ? 1'b0 : (m_in_done[i] | hi[i]);
            m_in_ld[i]   = frame_end ? 1'b0 : ((m_in_ld[i] & ~hi[i]) | in_data_loaded[i]);
        end
        for (int i = 0; i < NO; i++) begin
            m_out_en[i]   = out_arm[i] | (m_out_en[i] & ~ho[i]);
            m_out_done[i] = frame_end ? 1'b0 : (m_out_done[i] | ho[i]);
        end
        m_drop  = bad;
        m_cause = bad ? c : 3'b000;
    endtask

    task automatic compare_all();
        chk(in_enabled == m_in_en, "R2 in_enabled", 32'(in_enabled), 32'(m_in_en));
        chk(in_odd == m_in_odd, "R4 in_odd", 32'(in_odd), 32'(m_in_odd));
        chk(in_done == m_in_done, "R2 in_done", 32'(in_done), 32'(m_in_done));
        chk(out_enabled == m_out_en, "R7 out_enabled", 32'(out_enabled), 32'(m_out_en));
        chk(out_done == m_out_done, "R7 out_done", 32'(out_done), 32'(m_out_done));
        chk(out_drop == m_drop, "R6 out_drop", 32'(out_drop), 32'(m_drop));
        chk(out_drop_cause == m_cause, "R6 out_drop_cause", 32'(out_drop_cause), 32'(m_cause));
        chk(in_incomplete_irq == m_irq_in, "R5 in_incomplete_irq", 32'(in_incomplete_irq), 32'(m_irq_in));
        chk(out_incomplete_irq == m_irq_out, "R8 out_incomplete_irq", 32'(out_incomplete_irq), 32'(m_irq_out));
    endtask

    task automatic idle();
        frame_end = 0; in_arm = '0; in_set_even = '0; in_set_odd = '0; in_data_loaded = '0;
        in_tok_valid = 0; in_tok_ep = '0; in_tok_err = 0; out_arm = '0; out_pkt_valid = 0;
        out_pkt_ep = '0; out_pkt_len = '0; out_crc_ok = 1; out_tok_ok = 1; rx_fifo_free = 11'd512;
        in_irq_clr = 0; out_irq_clr = 0;
    endtask

    // one clock: model, edge, sample, then back to the falling edge
    task automatic step();
        logic fe;
        fe = frame_end;
        model_next();
        @(posedge clk);
        #1;
        compare_all();
        if (fe) frame_num = frame_num + 1'b1;
        @(negedge clk);
        idle();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        frame_num = '0;
        idle();
        rst = 1;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk({in_enabled, in_odd, in_done, out_enabled, out_done} == '0, "R1 vectors",
            32'({in_enabled, in_odd, in_done, out_enabled, out_done}), 0);
        chk({out_drop, out_drop_cause, in_incomplete_irq, out_incomplete_irq} == '0, "R1 flags",
            32'({out_drop, out_drop_cause, in_incomplete_irq, out_incomplete_irq}), 0);
        rst = 0;

        // R2: loaded, even endpoint in even frame, good token
        in_arm = 4'b0010; step();
        in_data_loaded = 4'b0010; step();
        in_tok_valid = 1; in_tok_ep = 2'd1; step();
        chk(in_done[1] && !in_enabled[1], "R2 completion", 32'({in_done[1], in_enabled[1]}), 32'h2);

        // R3: token before data, then token in error
        in_arm = 4'b0100; step();
        in_tok_valid = 1; in_tok_ep = 2'd2; step();
        chk(in_enabled[2] && !in_done[2], "R3 early token", 32'({in_enabled[2], in_done[2]}), 32'h2);
        in_data_loaded = 4'b0100; step();
        in_tok_valid = 1; in_tok_ep = 2'd2; in_tok_err = 1; step();
        chk(in_enabled[2] && !in_done[2], "R3 token error", 32'({in_enabled[2], in_done[2]}), 32'h2);

        // R4 and R5: odd endpoint not due in even frame, due in odd frame
        in_set_odd = 4'b0100; in_set_even = 4'b0100; step();
        chk(in_odd[2] == 1'b1, "R4 odd wins", 32'(in_odd[2]), 1);
        frame_end = 1; step();
        chk(in_incomplete_irq == 1'b0, "R5 parity mismatch", 32'(in_incomplete_irq), 0);
        chk(in_done[1] == 1'b0 && in_enabled[2], "R10 done wiped, arm kept",
            32'({in_done[1], in_enabled[2]}), 32'h1);
        frame_end = 1; step();
        chk(in_incomplete_irq == 1'b1, "R5 parity match", 32'(in_incomplete_irq), 1);

        // R9: raise with clear keeps set, clear alone drops
        in_set_even = 4'b0100; step();
        chk(in_odd[2] == 1'b0, "R4 set even", 32'(in_odd[2]), 0);
        frame_end = 1; in_irq_clr = 1; step();
        chk(in_incomplete_irq == 1'b1, "R9 raise beats clear", 32'(in_incomplete_irq), 1);
        in_irq_clr = 1; step();
        chk(in_incomplete_irq == 1'b0, "R9 clear", 32'(in_incomplete_irq), 0);

        // R6: each drop cause
        out_arm = 4'b0001; step();
        out_pkt_valid = 1; out_pkt_ep = 2'd0; out_pkt_len = 11'd100; rx_fifo_free = 11'd50; step();
        chk(out_drop && out_drop_cause == 3'b001, "R6 fifo short", 32'({out_drop, out_drop_cause}), 32'h9);
        chk(out_enabled[0] && !out_done[0], "R6 still armed", 32'({out_enabled[0], out_done[0]}), 32'h2);
        out_pkt_valid = 1; out_pkt_len = 11'd10; rx_fifo_free = 11'd50; out_crc_ok = 0; step();
        chk(out_drop_cause == 3'b010, "R6 crc", 32'(out_drop_cause), 32'h2);
        out_pkt_valid = 1; out_pkt_len = 11'd10; rx_fifo_free = 11'd50; out_tok_ok = 0; step();
        chk(out_drop_cause == 3'b100, "R6 token", 32'(out_drop_cause), 32'h4);
        // R7: length equal to free space is accepted
        out_pkt_valid = 1; out_pkt_len = 11'd50; rx_fifo_free = 11'd50; step();
        chk(out_done[0] && !out_enabled[0] && !out_drop, "R7 equal length",
            32'({out_done[0], out_enabled[0], out_drop}), 32'h4);
        // R7: unarmed endpoint
        out_pkt_valid = 1; out_pkt_ep = 2'd3; out_pkt_len = 11'd5; step();
        chk(!out_done[3] && !out_drop, "R7 unarmed", 32'({out_done[3], out_drop}), 0);

        // R10 and R8: transfer in the frame-end cycle is not credited
        out_arm = 4'b0010; step();
        frame_end = 1; out_pkt_valid = 1; out_pkt_ep = 2'd1; out_pkt_len = 11'd5; step();
        chk(!out_done[1] && out_enabled[1], "R10 frame-end transfer", 32'({out_done[1], out_enabled[1]}), 32'h1);
        chk(out_incomplete_irq == 1'b1, "R8 out incomplete", 32'(out_incomplete_irq), 1);

        // constrained random run
        void'($urandom(32'd20240613));
        for (int n = 0; n < 4000; n++) begin
            frame_end      = ($urandom % 20) == 0;
            in_arm         = (($urandom % 6) == 0) ? 4'($urandom) : '0;
            in_set_even    = (($urandom % 10) == 0) ? 4'($urandom) : '0;
            in_set_odd     = (($urandom % 10) == 0) ? 4'($urandom) : '0;
            in_data_loaded = (($urandom % 4) == 0) ? 4'($urandom) : '0;
            in_tok_valid   = ($urandom % 3) == 0;
            in_tok_ep      = 2'($urandom);
            in_tok_err     = ($urandom % 6) == 0;
            out_arm        = (($urandom % 6) == 0) ? 4'($urandom) : '0;
            out_pkt_valid  = ($urandom % 3) == 0;
            out_pkt_ep     = 2'($urandom);
            out_pkt_len    = 11'($urandom % 200);
            rx_fifo_free   = 11'($urandom % 256);
            out_crc_ok     = ($urandom % 8) != 0;
            out_tok_ok     = ($urandom % 10) != 0;
            in_irq_clr     = ($urandom % 12) == 0;
            out_irq_clr    = ($urandom % 12) == 0;
            step();
        end
        finish_run();
    end

endmodule